// File: doc/BRIEF.md
# Oversampled Pixel-Clock Byte Capture

This block brings a byte-wide video stream into a system clock domain that runs at exactly four times the pixel rate, with a stable but unknown phase. No FIFO is used. Each incoming word is first held in a register clocked by the pixel clock. The pixel clock is then treated as an ordinary data signal. It passes through a two-stage synchronizer in the system domain. A small edge-tracking state machine turns the synchronized level into a one-cycle load enable. That enable reloads the output register from the held copy while the held copy is known to be stable.

A parameter selects how the marker is formed. In rising mode the marker is the pixel clock itself, and only its low-to-high change produces a load. In toggle mode a pixel-domain flip-flop flips on every pixel rising edge, giving a half-rate square wave, and both changes of that wave produce a load. Toggle mode works even when the pixel clock's high time is far shorter than a system period.

The edge tracker has two states: `LVL_LOW` and `LVL_HIGH`. Each state holds the level of the synchronized marker from one cycle earlier. The tracker moves `LVL_LOW -> LVL_HIGH` when the synchronized marker reads 1, and `LVL_HIGH -> LVL_LOW` when it reads 0. Otherwise it stays where it is. In rising mode a load fires only on the `LVL_LOW -> LVL_HIGH` transition. In toggle mode a load fires on either transition.

Top module: `pixel_capture_top`

## Requirements
- R1: While `sys_rst` is high, and after it falls until the first load, `out_valid` is 0 and `out_data` is 0.
- R2: The delivered word is the value present on `pix_data` at a rising edge of `pix_clk`.
- R3: `out_valid` for a word is first high after the third rising edge of `sys_clk` that follows the pixel rising edge. The latency is more than two and at most three system periods.
- R4: With `MODE` = 0 and a pixel high time of at least a quarter of the pixel period, exactly one word is delivered per pixel rising edge.
- R5: `out_valid` is high for exactly one system cycle per word. In a steady stream, consecutive pulses are exactly four system cycles apart.
- R6: `out_data` changes only in a cycle where `out_valid` is high, and holds its value in every other cycle.
- R7: With `MODE` = 1, exactly one word is delivered per pixel rising edge, including for pixel high pulses shorter than one system period.
- R8: For any fixed phase between the clocks, every word is delivered exactly once and in order, with none missing or duplicated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sys_clk | input | 1 | System clock, four times the pixel rate |
| sys_rst | input | 1 | Synchronous active-high reset for the system domain |
| pix_clk | input | 1 | External pixel clock |
| pix_rst | input | 1 | Asynchronous active-high reset for the pixel-domain registers |
| pix_data | input | DATA_W | Incoming word, launched by the pixel clock |
| out_data | output | DATA_W | Word re-timed into the system domain |
| out_valid | output | 1 | One-cycle strobe marking a newly loaded `out_data` |

## Verification
The bench sweeps the phase of the pixel clock across the whole system period in fractional steps. It also covers both long and very short pixel high times, with one instance per mode sharing the same stimulus. At each phase it checks three things. First, a counting data pattern must arrive gap-free and without repeats: a stage missing from the synchronizer or an early load would deliver the word before or after the one expected. Second, the latency must fall inside its window. Third, strobes must be spaced exactly four cycles apart: an edge detector that fires on both levels in rising mode would double words or break this spacing. Short-pulse runs check that toggle mode still sees every edge; an XOR replaced by an AND would lose every other word there. Between strobes, any drift of the output word is reported.

// File: rtl/cap_pkg.sv
package cap_pkg;
    localparam int MODE_RISE   = 0;
    localparam int MODE_TOGGLE = 1;

    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } lvl_state_t;
endpackage

// File: rtl/cap_launch.sv
module cap_launch #(
    parameter int DATA_W = 8,
    parameter int MODE   = 0
) (
    input  logic              pix_clk,
    input  logic              pix_rst,
    input  logic [DATA_W-1:0] pix_data,
    output logic [DATA_W-1:0] held_data,
    output logic              marker
);
    import cap_pkg::*;

    // Word held in the pixel domain for a whole pixel period.
    always_ff @(posedge pix_clk or posedge pix_rst) begin
        if (pix_rst) held_data <= '0;
        else         held_data <= pix_data;
    end

    generate
        if (MODE == MODE_TOGGLE) begin : g_toggle
            logic flip_q;
            always_ff @(posedge pix_clk or posedge pix_rst) begin
                if (pix_rst) flip_q <= 1'b0;
                else         flip_q <= ~flip_q;
            end
            assign marker = flip_q;
        end else begin : g_rise
            assign marker = pix_clk;
        end
    endgenerate
endmodule

// File: rtl/cap_sync.sv
module cap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    localparam int TOP = STAGES - 1;

    logic [TOP:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[TOP-1:0], din};
    end

    assign dout = chain[TOP];

    // R3: the output level only moves after the stage before it differed
    p_sync_no_skip_r3: assert property (@(posedge clk) disable iff (rst)
        !$stable(dout) |-> ($past(chain[TOP-1]) != $past(dout)));
endmodule

// File: rtl/cap_edge.sv
module cap_edge #(
    parameter int MODE = 0
) (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic load_en
);
    import cap_pkg::*;

    lvl_state_t state, next_state;

    always_comb begin
        next_state = state;
        unique case (state)
            LVL_LOW:  if (lvl)  next_state = LVL_HIGH;
            LVL_HIGH: if (!lvl) next_state = LVL_LOW;
            default:            next_state = LVL_LOW;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= LVL_LOW;
        else     state <= next_state;
    end

    always_comb begin
        load_en = 1'b0;
        unique case (state)
            LVL_LOW:  load_en = lvl;
            LVL_HIGH: load_en = (MODE == MODE_TOGGLE) ? !lvl : 1'b0;
            default:  load_en = 1'b0;
        endcase
    end

    generate
        if (MODE == MODE_TOGGLE) begin : g_chk_toggle
            // R7: each load matches a change of the synchronized marker
            p_toggle_change_r7: assert property (@(posedge clk) disable iff (rst)
                load_en |-> (lvl != $past(lvl)));
        end else begin : g_chk_rise
            // R4: a load only fires while the synchronized marker is high
            p_rise_only_r4: assert property (@(posedge clk) disable iff (rst)
                load_en |-> (lvl && !$past(lvl)));
        end
    endgenerate
endmodule

// File: rtl/pixel_capture_top.sv
module pixel_capture_top #(
    parameter int DATA_W      = 8,
    parameter int MODE        = 0,
    parameter int SYNC_STAGES = 2
) (
    input  logic              sys_clk,
    input  logic              sys_rst,
    input  logic              pix_clk,
    input  logic              pix_rst,
    input  logic [DATA_W-1:0] pix_data,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid
);
    logic [DATA_W-1:0] held_data;
    logic              marker;
    logic              marker_sync;
    logic              load_en;

    cap_launch #(.DATA_W(DATA_W), .MODE(MODE)) u_launch (
        .pix_clk  (pix_clk),
        .pix_rst  (pix_rst),
        .pix_data (pix_data),
        .held_data(held_data),
        .marker   (marker)
    );

    cap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (sys_clk),
        .rst (sys_rst),
        .din (marker),
        .dout(marker_sync)
    );

    cap_edge #(.MODE(MODE)) u_edge (
        .clk    (sys_clk),
        .rst    (sys_rst),
        .lvl    (marker_sync),
        .load_en(load_en)
    );

    always_ff @(posedge sys_clk) begin
        if (sys_rst) begin
            out_data  <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= load_en;
            if (load_en) out_data <= held_data;
        end
    end

    // R5: strobe never lasts two cycles
    p_valid_pulse_r5: assert property (@(posedge sys_clk) disable iff (sys_rst)
        out_valid |=> !out_valid);

    // R6: output word is frozen outside strobe cycles
    p_data_hold_r6: assert property (@(posedge sys_clk) disable iff (sys_rst)
        !out_valid |-> $stable(out_data));

    // R1: no strobe in the cycle right after reset
    p_reset_quiet_r1: assert property (@(posedge sys_clk)
        $past(sys_rst) |-> !out_valid);
endmodule

// File: tb/test_pixel_capture_top.sv
`timescale 1ns/100ps
module test_pixel_capture_top;
    localparam int W = 8;

    logic         sys_clk = 1'b0;
    logic         sys_rst = 1'b1;
    logic         pix_clk = 1'b0;
    logic         pix_rst = 1'b1;
    logic [W-1:0] pix_data = '0;
    logic [W-1:0] data_a, data_b;
    logic         valid_a, valid_b;

    int  n_tests = 0;
    int  n_fail  = 0;
    int  exp_a = 0, exp_b = 0;
    int  got_a = 0, got_b = 0, sent_a = 0, sent_b = 0;
    bit  chk_a = 1'b1, running = 1'b0;
    real t_rise = 0.0, last_a = -1.0, last_b = -1.0;
    logic [W-1:0] prev_a = '0, prev_b = '0;

    always #5 sys_clk = ~sys_clk;

    pixel_capture_top #(.DATA_W(W), .MODE(0)) i_pixel_capture_top (
        .sys_clk(sys_clk), .sys_rst(sys_rst), .pix_clk(pix_clk), .pix_rst(pix_rst),
        .pix_data(pix_data), .out_data(data_a), .out_valid(valid_a));

    pixel_capture_top #(.DATA_W(W), .MODE(1)) i_pixel_capture_top_t (
        .sys_clk(sys_clk), .sys_rst(sys_rst), .pix_clk(pix_clk), .pix_rst(pix_rst),
        .pix_data(pix_data), .out_data(data_b), .out_valid(valid_b));

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Sampling on the falling edge, away from the active edge.
    always @(negedge sys_clk) begin
        if (!sys_rst && running) begin
            real lat;
            lat = $realtime - 5.0 - t_rise;
            if (chk_a) begin
                if (valid_a) begin
                    check(data_a == W'(exp_a), "R2/R4/R8 rise-mode word", int'(data_a), exp_a & 8'hFF);
                    check(lat > 20.0 && lat <= 30.0, "R3 rise-mode latency", int'(lat), 30);
                    if (last_a >= 0.0)
                        check(($realtime - last_a) == 40.0, "R5 rise-mode spacing",
                              int'($realtime - last_a), 40);
                    last_a = $realtime;
                    exp_a++;
                    got_a++;
                end else begin
                    check(data_a == prev_a, "R6 rise-mode hold", int'(data_a), int'(prev_a));
                end
                prev_a = data_a;
            end
            if (valid_b) begin
                check(data_b == W'(exp_b), "R7/R8 toggle-mode word", int'(data_b), exp_b & 8'hFF);
                check(lat > 20.0 && lat <= 30.0, "R3 toggle-mode latency", int'(lat), 30);
                if (last_b >= 0.0)
                    check(($realtime - last_b) == 40.0, "R5 toggle-mode spacing",
                          int'($realtime - last_b), 40);
                last_b = $realtime;
                exp_b++;
                got_b++;
            end else begin
                check(data_b == prev_b, "R6 toggle-mode hold", int'(data_b), int'(prev_b));
            end
            prev_b = data_b;
        end
    end

    task automatic run_words(input real ph, input real hi, input int n);
        @(posedge sys_clk);
        #(ph);
        last_a = -1.0;
        last_b = -1.0;
        for (int i = 0; i < n; i++) begin
            pix_clk = 1'b1;
            t_rise  = $realtime;
            if (chk_a) sent_a++;
            sent_b++;
            #1.0 pix_data = pix_data + 1'b1;
            #(hi - 1.0) pix_clk = 1'b0;
            #(40.0 - hi);
        end
        #80.0;
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(posedge sys_clk);
        #1;
        // R1: reset state
        check(valid_a == 1'b0 && data_a == '0, "R1 rise-mode reset", int'(data_a), 0);
        check(valid_b == 1'b0 && data_b == '0, "R1 toggle-mode reset", int'(data_b), 0);
        pix_rst = 1'b0;
        @(negedge sys_clk);
        sys_rst = 1'b0;
        repeat (3) @(negedge sys_clk);
        check(valid_a == 1'b0 && data_a == '0, "R1 rise-mode idle after reset", int'(valid_a), 0);
        check(valid_b == 1'b0 && data_b == '0, "R1 toggle-mode idle after reset", int'(valid_b), 0);
        running = 1'b1;

        // R4/R8: phase sweep with long high times, both instances checked
        for (int k = 0; k < 10; k++) begin
            run_words(0.5 + real'(k), 20.0, 24);
            run_words(0.3 + real'(k), 11.0, 24);
        end
        check(got_a == sent_a, "R8 rise-mode word count", got_a, sent_a);

        // R7: short pulses, only the toggle instance is checked
        chk_a = 1'b0;
        for (int k = 0; k < 10; k++) begin
            run_words(0.7 + real'(k), 3.0, 24);
        end
        check(got_b == sent_b, "R7/R8 toggle-mode word count", got_b, sent_b);

        running = 1'b0;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule